// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain wires, one facing a card and one facing a host, so that a low pulled on either wire is copied onto the other. Direction is not wired in. It is chosen for each transaction: the wire that falls first becomes the master, and the other wire becomes the slave, which the block then pulls low. Both wire levels pass through a synchronizer. After that, a falling-edge detector that is armed only while the block is idle chooses the master. A transfer delay, counted in system clock cycles, separates the master's fall from the slave pull-down. When the master goes high again, the block lets go of the slave and raises that side's booster enable for the same number of cycles.

A larger design places one instance on the data wire and one on each auxiliary wire. The pull-up resistors and the booster current source are outside the block, so each side has only a sampled input, an active-low pull-down enable and a booster enable. When an external device holds the slave low, the wires are in conflict. In that case the block releases both wires and ignores new edges until it sees both wires high, so it can never lock itself low.

Top module: `odr_line_repeater`

## Requirements
- R1: During reset and on the first cycle after it, both pull-down enables are high (released) and both booster enables are low.
- R2: After a card-side fall, host_pull_n_o goes low at clock edge SYNC_STAGES+1+DELAY_CYC, counted from the first rising edge after the card wire changed.
- R3: After a host-side fall, card_pull_n_o goes low with the same latency as in R2.
- R4: The block never pulls the master wire low, and never pulls both wires low at once. The slave wire going low because of the block's own pull-down never reverses the direction.
- R5: A master low lasting DELAY_CYC clock cycles or fewer is not transferred. The slave stays released, no booster pulse follows, and the block re-arms.
- R6: The slave pull-down is held until the synchronized master level is high, and is released at edge L+SYNC_STAGES+1 for a master low of L cycles. This leaves the slave pulled low for L−DELAY_CYC cycles.
- R7: When the slave is released, that side's booster enable is high for exactly DELAY_CYC cycles, starting on the same edge as the release. The master side's booster is never raised.
- R8: When both wires fall in the same sampled cycle, the card side becomes master and only the host side is pulled low.
- R9: If either wire is still low when the booster pulse ends, or when a master releases during the delay, the block releases both wires and ignores falls. It returns to idle and re-arms once both synchronized levels are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_line_i | input | 1 | Sampled level of the card-side wire |
| host_line_i | input | 1 | Sampled level of the host-side wire |
| card_pull_n_o | output | 1 | Card-side pull-down enable, low pulls the wire down |
| host_pull_n_o | output | 1 | Host-side pull-down enable, low pulls the wire down |
| card_boost_o | output | 1 | Card-side booster enable, high for the release pulse |
| host_boost_o | output | 1 | Host-side booster enable, high for the release pulse |

## Verification
The hardest case to reach from the ports is the held-conflict condition. In that condition the block has released everything but must stay unarmed, because one wire is still held low from outside. The stimulus starts a card-to-host transfer, pulls the host wire low externally inside the delay window, and keeps it low past the end of the booster pulse. A fresh card fall is then applied while the conflict holds, to show that it is ignored. Only after the host wire is freed does a host-first transfer confirm that the block re-armed. The ordinary transfers are swept over every low length from 1 to 14 cycles in both directions, so the cut-off between filtered and transferred pulses and the exact edges of the drive and booster windows are all checked.

// File: rtl/odr_pkg.sv
package odr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_DRIVE = 3'd2,
      ST_BOOST = 3'd3,
      ST_HOLD  = 3'd4
   } rep_state_e;

   typedef enum logic {
      SIDE_CARD = 1'b0,
      SIDE_HOST = 1'b1
   } side_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
   parameter int   W       = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int CHAIN_W = W * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("odr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {CHAIN_W{RST_LVL}};
      else        chain <= {chain[CHAIN_W-W-1:0], din};
   end

   assign dout = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/odr_edge_arb.sv
module odr_edge_arb
   import odr_pkg::*;
#(
   parameter bit CARD_WINS_TIE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic [1:0] lvl_s,
   output logic       fall_seen,
   output side_e      winner
);
   logic [1:0] lvl_q;
   logic [1:0] fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 2'b11;
      else        lvl_q <= lvl_s;
   end

   assign fall      = lvl_q & ~lvl_s & {2{arm}};
   assign fall_seen = |fall;

   generate
      if (CARD_WINS_TIE) begin : g_card_first
         assign winner = fall[0] ? SIDE_CARD : SIDE_HOST;
      end else begin : g_host_first
         assign winner = fall[1] ? SIDE_HOST : SIDE_CARD;
      end
   endgenerate

endmodule

// File: rtl/odr_xfer_fsm.sv
module odr_xfer_fsm
   import odr_pkg::*;
#(
   parameter int DELAY_CYC = 25
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  fall_seen,
   input  side_e winner,
   input  logic  card_s,
   input  logic  host_s,
   output logic  arm,
   output logic  drv_card,
   output logic  drv_host,
   output logic  bst_card,
   output logic  bst_host
);
   localparam int CNT_W = cnt_width(DELAY_CYC);
   localparam int RUN_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYC - 1);

   rep_state_e       st, st_n;
   side_e            mst, mst_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             master_hi, quiet, cnt_zero;

   assign master_hi = (mst == SIDE_CARD) ? card_s : host_s;
   assign quiet     = card_s & host_s;
   assign cnt_zero  = (cnt == '0);

   always_comb begin
      st_n  = st;
      mst_n = mst;
      cnt_n = cnt;
      unique case (st)
         ST_IDLE: begin
            if (fall_seen) begin
               st_n  = ST_WAIT;
               mst_n = winner;
               cnt_n = CNT_LOAD;
            end
         end
         ST_WAIT: begin
            if (master_hi)     st_n = quiet ? ST_IDLE : ST_HOLD;
            else if (cnt_zero) st_n = ST_DRIVE;
            else               cnt_n = cnt - 1'b1;
         end
         ST_DRIVE: begin
            if (master_hi) begin
               st_n  = ST_BOOST;
               cnt_n = CNT_LOAD;
            end
         end
         ST_BOOST: begin
            if (cnt_zero) st_n = quiet ? ST_IDLE : ST_HOLD;
            else          cnt_n = cnt - 1'b1;
         end
         ST_HOLD: begin
            if (quiet) st_n = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         mst <= SIDE_CARD;
         cnt <= '0;
      end else begin
         st  <= st_n;
         mst <= mst_n;
         cnt <= cnt_n;
      end
   end

   assign arm      = (st == ST_IDLE);
   assign drv_host = (st == ST_DRIVE) && (mst == SIDE_CARD);
   assign drv_card = (st == ST_DRIVE) && (mst == SIDE_HOST);
   assign bst_host = (st == ST_BOOST) && (mst == SIDE_CARD);
   assign bst_card = (st == ST_BOOST) && (mst == SIDE_HOST);

   // Length of the current booster pulse, kept for the pulse-width check.
   logic [RUN_W-1:0] bst_run;
   logic             bst_any;
   assign bst_any = bst_card | bst_host;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bst_run <= '0;
      else if (bst_any) bst_run <= bst_run + 1'b1;
      else              bst_run <= '0;
   end

   assert_boost_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bst_any) |-> (bst_run == RUN_W'(DELAY_CYC)));

   assert_drive_after_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_card | drv_host) |-> ($past(st) == ST_WAIT));

   assert_hold_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && card_s && host_s) |=> (st == ST_IDLE));

   assert_hold_ignores_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && !(card_s && host_s)) |=> (st == ST_HOLD));

endmodule

// File: rtl/odr_line_repeater.sv
module odr_line_repeater
   import odr_pkg::*;
#(
   parameter int DELAY_CYC     = 25,
   parameter int SYNC_STAGES   = 2,
   parameter bit CARD_WINS_TIE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic card_line_i,
   input  logic host_line_i,
   output logic card_pull_n_o,
   output logic host_pull_n_o,
   output logic card_boost_o,
   output logic host_boost_o
);
   localparam int MIN_DELAY = SYNC_STAGES + 1;

   generate
      if (DELAY_CYC < MIN_DELAY) begin : g_bad_delay
         $error("odr_line_repeater: DELAY_CYC must cover the synchronizer latency");
      end
   endgenerate

   logic [1:0] lvl_s;
   logic       card_s, host_s;
   logic       arm, fall_seen;
   side_e      winner;
   logic       drv_card, drv_host, bst_card, bst_host;

   odr_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_LVL (1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({host_line_i, card_line_i}),
      .dout (lvl_s)
   );

   assign card_s = lvl_s[0];
   assign host_s = lvl_s[1];

   odr_edge_arb #(
      .CARD_WINS_TIE(CARD_WINS_TIE)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .lvl_s    (lvl_s),
      .fall_seen(fall_seen),
      .winner   (winner)
   );

   odr_xfer_fsm #(
      .DELAY_CYC(DELAY_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_seen(fall_seen),
      .winner   (winner),
      .card_s   (card_s),
      .host_s   (host_s),
      .arm      (arm),
      .drv_card (drv_card),
      .drv_host (drv_host),
      .bst_card (bst_card),
      .bst_host (bst_host)
   );

   assign card_pull_n_o = ~drv_card;
   assign host_pull_n_o = ~drv_host;
   assign card_boost_o  = bst_card;
   assign host_boost_o  = bst_host;

   assert_single_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!card_pull_n_o && !host_pull_n_o));

   assert_boost_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_boost_o && (host_boost_o || !card_pull_n_o)) && !(host_boost_o && !host_pull_n_o));

   assert_host_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_host && card_s) |=> !drv_host);

   assert_card_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_card && host_s) |=> !drv_card);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (card_pull_n_o && host_pull_n_o && !card_boost_o && !host_boost_o));

endmodule

// File: tb/tb_odr_line_repeater.sv
module tb_odr_line_repeater;
   localparam int D = 4;
   localparam int S = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic card_ext_n = 1'b1;
   logic host_ext_n = 1'b1;
   logic card_line, host_line;
   logic card_pull_n, host_pull_n, card_boost, host_boost;

   // wire-AND of the external driver and the repeater's pull-down
   assign card_line = card_ext_n & card_pull_n;
   assign host_line = host_ext_n & host_pull_n;

   odr_line_repeater #(
      .DELAY_CYC    (D),
      .SYNC_STAGES  (S),
      .CARD_WINS_TIE(1'b1)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .card_line_i  (card_line),
      .host_line_i  (host_line),
      .card_pull_n_o(card_pull_n),
      .host_pull_n_o(host_pull_n),
      .card_boost_o (card_boost),
      .host_boost_o (host_boost)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_all(input string tag, input bit cp, input bit hp, input bit cb, input bit hb);
      chk({tag, " card pull"},  ~card_pull_n, cp);
      chk({tag, " host pull"},  ~host_pull_n, hp);
      chk({tag, " card boost"}, card_boost,   cb);
      chk({tag, " host boost"}, host_boost,   hb);
   endtask

   // One transfer: master held low for L cycles; with tie both wires fall together.
   task automatic pulse(input bit card_master, input bit tie, input int L);
      bit    xfer;
      bit    e_pull, e_bst;
      string tag;
      xfer = (L >= D + 1);
      @(negedge clk);
      if (card_master || tie) card_ext_n = 1'b0;
      if (!card_master || tie) host_ext_n = 1'b0;
      for (int k = 1; k <= L + S + D + 6; k++) begin
         @(posedge clk);
         @(negedge clk);
         e_pull = xfer && (k >= S + 1 + D) && (k <= L + S);
         e_bst  = xfer && (k >= L + S + 1) && (k <= L + S + D);
         if (tie)                 tag = "R8 tie";
         else if (!xfer)          tag = "R5 short";
         else if (k == S + 1 + D) tag = card_master ? "R2 delay" : "R3 delay";
         else                     tag = card_master ? "R6 hold/R2" : "R6 hold/R3";
         if (card_master || tie) begin
            chk({tag, " slave host pull"}, ~host_pull_n, e_pull);
            chk("R4 master card pull", ~card_pull_n, 1'b0);
            chk("R7 slave host boost", host_boost, e_bst);
            chk("R7 master card boost", card_boost, 1'b0);
         end else begin
            chk({tag, " slave card pull"}, ~card_pull_n, e_pull);
            chk("R4 master host pull", ~host_pull_n, 1'b0);
            chk("R7 slave card boost", card_boost, e_bst);
            chk("R7 master host boost", host_boost, 1'b0);
         end
         if (k == L) begin
            card_ext_n = 1'b1;
            host_ext_n = 1'b1;
         end
      end
      repeat (3) @(negedge clk);
   endtask

   // Conflict: host held low from outside across the whole transfer.
   task automatic conflict_case();
      bit e_hp, e_hb;
      @(negedge clk);
      card_ext_n = 1'b0;
      for (int k = 1; k <= 32; k++) begin
         @(posedge clk);
         @(negedge clk);
         e_hp = (k >= S + 1 + D) && (k <= 10 + S);
         e_hb = (k >= 10 + S + 1) && (k <= 10 + S + D);
         chk_all("R9 conflict", 1'b0, e_hp, 1'b0, e_hb);
         if (k == 5)  host_ext_n = 1'b0;
         if (k == 10) card_ext_n = 1'b1;
         if (k == 20) card_ext_n = 1'b0;
         if (k == 24) card_ext_n = 1'b1;
         if (k == 26) host_ext_n = 1'b1;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_all("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b0);

      for (int L = 1; L <= 14; L++) pulse(1'b1, 1'b0, L);
      for (int L = 1; L <= 14; L++) pulse(1'b0, 1'b0, L);
      pulse(1'b1, 1'b1, 8);
      pulse(1'b1, 1'b1, 3);

      conflict_case();
      // R9 re-arm after the conflict clears
      pulse(1'b0, 1'b0, 7);
      pulse(1'b1, 1'b0, 9);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule